// File: doc/BRIEF.md
# Iterative Multiply-Accumulate Unit

This block multiplies two 32-bit operands over several clock cycles and can add a caller-supplied accumulator to the product. Six operation codes give two result widths. The short forms keep only the low 32 bits of the result. The long forms keep the full 64-bit result and treat the operands as either signed or unsigned. The accumulator is 32 or 64 bits wide, matching the result width.

The datapath takes the multiplier 8 bits per cycle. It stops as soon as the bits still unconsumed are all zero, or all ones for a two's-complement multiplier. A small multiplier therefore finishes in fewer cycles than a wide one. The caller pulses `start_i` with the operands while the unit is idle. It then waits for the one-cycle `done_o` pulse and reads `result_o`, which holds its value until the next completion. Writing the result back to a register file and setting flags are the caller's job.

Top module: `mac_iter_unit`

## Requirements
- R1: While reset is applied and right after it is released, `busy_o` is 0, `done_o` is 0 and `result_o` is 0.
- R2: Operation code 0 (and the unused codes 6 and 7) yields the low 32 bits of mcand×mplier in `result_o[31:0]`, with `result_o[63:32]` = 0.
- R3: Operation code 1 yields the low 32 bits of mcand×mplier + `acc_i[31:0]`, with `result_o[63:32]` = 0. `acc_i[63:32]` has no effect.
- R4: Operation code 2 yields the full 64-bit product, with both operands taken as unsigned.
- R5: Operation code 3 yields the full 64-bit product, with both operands taken as two's complement.
- R6: Operation codes 4 (unsigned) and 5 (signed) yield the 64-bit product plus `acc_i`, modulo 2^64.
- R7: `busy_o` is high from the edge that accepts `start_i` until the edge that raises `done_o`. While `done_o` is high, `busy_o` is low. `done_o` lasts exactly one cycle.
- R8: A `start_i` pulse that arrives while `busy_o` is high is ignored. The operation in flight completes with its own result, and no second operation starts.
- R9: Let k be the number of 8-bit multiplier digits consumed before the remaining multiplier is all zeros, or all ones when the multiplier is signed. The multiplier is signed for codes 0, 1, 3, 5, 6 and 7. `done_o` rises k+1 clock edges after the accepting edge, with 0 ≤ k ≤ 4.
- R10: `result_o` changes only on the edge that raises `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launches an operation when the unit is idle |
| op_i | input | 3 | Operation code (see R2 to R6) |
| mcand_i | input | 32 | Multiplicand operand |
| mplier_i | input | 32 | Multiplier operand, consumed 8 bits per cycle |
| acc_i | input | 64 | Accumulator addend, high word in bits 63:32 |
| result_o | output | 64 | Last completed result |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that `start_i` comes only from a caller that follows the handshake. Operands are sampled only on the accepting edge, so their values at any other time may be anything. They also assume that reset is released synchronously to the clock. The stimulus meets these assumptions by driving every input on the falling edge. It clears `start_i` on the same falling edge where it sees `done_o`, so no operation is launched by accident. In selected runs it deliberately keeps `start_i` high with junk operands throughout the busy window. Those runs exercise the rule that a start pulse is ignored while the unit is busy, without breaking the assumptions above.

// File: rtl/mac_iter_pkg.sv
package mac_iter_pkg;

    typedef enum logic [2:0] {
        OP_LO        = 3'd0,
        OP_LO_ACC    = 3'd1,
        OP_LONG_U    = 3'd2,
        OP_LONG_S    = 3'd3,
        OP_LONG_UACC = 3'd4,
        OP_LONG_SACC = 3'd5
    } mac_op_e;

    typedef struct packed {
        logic        is_long;
        logic        mcand_signed;
        logic        mplier_signed;
        logic        acc_en;
    } mac_ctrl_t;

    function automatic mac_ctrl_t decode_op(input logic [2:0] op);
        mac_ctrl_t c;
        c = '{is_long: 1'b0, mcand_signed: 1'b0, mplier_signed: 1'b1, acc_en: 1'b0};
        case (op)
            OP_LO_ACC:    c.acc_en = 1'b1;
            OP_LONG_U:    begin c.is_long = 1'b1; c.mplier_signed = 1'b0; end
            OP_LONG_S:    begin c.is_long = 1'b1; c.mcand_signed = 1'b1; end
            OP_LONG_UACC: begin c.is_long = 1'b1; c.mplier_signed = 1'b0; c.acc_en = 1'b1; end
            OP_LONG_SACC: begin c.is_long = 1'b1; c.mcand_signed = 1'b1; c.acc_en = 1'b1; end
            default:      c.acc_en = 1'b0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/mac_operand_prep.sv
module mac_operand_prep
    import mac_iter_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [2:0]         op_i,
    input  logic [WIDTH-1:0]   mcand_i,
    input  logic [WIDTH-1:0]   mplier_i,
    input  logic [2*WIDTH-1:0] acc_i,
    output logic               is_long_o,
    output logic [2*WIDTH-1:0] mcand_ext_o,
    output logic [WIDTH:0]     mplier_ext_o,
    output logic [2*WIDTH-1:0] acc_init_o
);
    mac_ctrl_t ctrl;

    always_comb begin
        ctrl         = decode_op(op_i);
        is_long_o    = ctrl.is_long;
        mcand_ext_o  = {{WIDTH{ctrl.mcand_signed & mcand_i[WIDTH-1]}}, mcand_i};
        mplier_ext_o = {ctrl.mplier_signed & mplier_i[WIDTH-1], mplier_i};
        if (!ctrl.acc_en)
            acc_init_o = '0;
        else if (ctrl.is_long)
            acc_init_o = acc_i;
        else
            acc_init_o = {{WIDTH{1'b0}}, acc_i[WIDTH-1:0]};
    end
endmodule

// File: rtl/mac_digit_step.sv
module mac_digit_step #(
    parameter int WIDTH = 32,
    parameter int DIGIT = 8
) (
    input  logic [2*WIDTH-1:0] acc_i,
    input  logic [2*WIDTH-1:0] mcand_i,
    input  logic [WIDTH:0]     mplier_i,
    output logic               term_o,
    output logic [2*WIDTH-1:0] acc_fin_o,
    output logic [2*WIDTH-1:0] acc_nxt_o,
    output logic [2*WIDTH-1:0] mcand_nxt_o,
    output logic [WIDTH:0]     mplier_nxt_o
);
    localparam int RW = 2 * WIDTH;

    logic [RW-1:0] part [DIGIT+1];
    logic          rem_zero;
    logic          rem_ones;

    assign part[0] = '0;

    for (genvar i = 0; i < DIGIT; i++) begin : g_pp
        assign part[i+1] = part[i] + (mplier_i[i] ? (mcand_i << i) : {RW{1'b0}});
    end

    always_comb begin
        rem_zero     = (mplier_i == '0);
        rem_ones     = &mplier_i;
        term_o       = rem_zero | rem_ones;
        acc_fin_o    = rem_ones ? (acc_i - mcand_i) : acc_i;
        acc_nxt_o    = acc_i + part[DIGIT];
        mcand_nxt_o  = mcand_i << DIGIT;
        mplier_nxt_o = $signed(mplier_i) >>> DIGIT;
    end
endmodule

// File: rtl/mac_iter_unit.sv
module mac_iter_unit #(
    parameter int WIDTH = 32,
    parameter int DIGIT = 8
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 start_i,
    input  logic [2:0]           op_i,
    input  logic [WIDTH-1:0]     mcand_i,
    input  logic [WIDTH-1:0]     mplier_i,
    input  logic [2*WIDTH-1:0]   acc_i,
    output logic [2*WIDTH-1:0]   result_o,
    output logic                 busy_o,
    output logic                 done_o
);
    localparam int RW     = 2 * WIDTH;
    localparam int DIGITS = (WIDTH + DIGIT - 1) / DIGIT;
    localparam int CW     = $clog2(DIGITS + 2);

    typedef struct packed {
        logic          busy;
        logic          done;
        logic          is_long;
        logic [CW-1:0] steps;
        logic [RW-1:0] acc;
        logic [RW-1:0] mcand;
        logic [WIDTH:0] mplier;
        logic [RW-1:0] result;
    } mac_state_t;

    mac_state_t st_d, st_q;

    logic           prep_long;
    logic [RW-1:0]  prep_mcand;
    logic [WIDTH:0] prep_mplier;
    logic [RW-1:0]  prep_acc;
    logic           step_term;
    logic [RW-1:0]  step_fin;
    logic [RW-1:0]  step_acc;
    logic [RW-1:0]  step_mcand;
    logic [WIDTH:0] step_mplier;

    mac_operand_prep #(.WIDTH(WIDTH)) prep_i (
        .op_i        (op_i),
        .mcand_i     (mcand_i),
        .mplier_i    (mplier_i),
        .acc_i       (acc_i),
        .is_long_o   (prep_long),
        .mcand_ext_o (prep_mcand),
        .mplier_ext_o(prep_mplier),
        .acc_init_o  (prep_acc)
    );

    mac_digit_step #(.WIDTH(WIDTH), .DIGIT(DIGIT)) step_i (
        .acc_i       (st_q.acc),
        .mcand_i     (st_q.mcand),
        .mplier_i    (st_q.mplier),
        .term_o      (step_term),
        .acc_fin_o   (step_fin),
        .acc_nxt_o   (step_acc),
        .mcand_nxt_o (step_mcand),
        .mplier_nxt_o(step_mplier)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (start_i) begin
                st_d.busy    = 1'b1;
                st_d.is_long = prep_long;
                st_d.steps   = '0;
                st_d.acc     = prep_acc;
                st_d.mcand   = prep_mcand;
                st_d.mplier  = prep_mplier;
            end
        end else if (step_term) begin
            st_d.busy   = 1'b0;
            st_d.done   = 1'b1;
            st_d.acc    = step_fin;
            st_d.result = st_q.is_long ? step_fin : {{WIDTH{1'b0}}, step_fin[WIDTH-1:0]};
        end else begin
            st_d.acc    = step_acc;
            st_d.mcand  = step_mcand;
            st_d.mplier = step_mplier;
            st_d.steps  = st_q.steps + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign result_o = st_q.result;
    assign busy_o   = st_q.busy;
    assign done_o   = st_q.done;

    // R7
    done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !busy_o);
    // R7
    done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);
    // R7
    busy_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(busy_o) |-> done_o);
    // R8
    busy_launch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_o) |-> $past(start_i));
    // R9
    step_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |-> (st_q.steps <= CW'(DIGITS)));
    // R10
    result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_o |-> $stable(result_o));
endmodule

// File: tb/mac_iter_unit_tb_top.sv
module mac_iter_unit_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        start_i = 1'b0;
    logic [2:0]  op_i = '0;
    logic [31:0] mcand_i = '0;
    logic [31:0] mplier_i = '0;
    logic [63:0] acc_i = '0;
    logic [63:0] result_o;
    logic        busy_o;
    logic        done_o;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;
    logic [31:0] lcg = 32'h1bad5eed;

    always #(CLK_PERIOD/2) clk_i = ~clk_i;

    mac_iter_unit dut_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .op_i(op_i),
        .mcand_i(mcand_i), .mplier_i(mplier_i), .acc_i(acc_i),
        .result_o(result_o), .busy_o(busy_o), .done_o(done_o)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic string op_tag(input logic [2:0] op);
        case (op)
            3'd1:       return "R3";
            3'd2:       return "R4";
            3'd3:       return "R5";
            3'd4, 3'd5: return "R6";
            default:    return "R2";
        endcase
    endfunction

    function automatic logic [63:0] ref_result(input logic [2:0] op, input logic [31:0] a,
                                               input logic [31:0] b, input logic [63:0] acc);
        logic [63:0] ea, eb, p;
        logic        sgn;
        sgn = (op == 3'd3) || (op == 3'd5);
        ea  = sgn ? {{32{a[31]}}, a} : {32'h0, a};
        eb  = sgn ? {{32{b[31]}}, b} : {32'h0, b};
        p   = ea * eb;
        case (op)
            3'd1:       return {32'h0, p[31:0] + acc[31:0]};
            3'd2, 3'd3: return p;
            3'd4, 3'd5: return p + acc;
            default:    return {32'h0, p[31:0]};
        endcase
    endfunction

    function automatic int ref_digits(input logic [2:0] op, input logic [31:0] b);
        logic [63:0] r;
        int k;
        r = (op == 3'd2 || op == 3'd4) ? {32'h0, b} : {{32{b[31]}}, b};
        k = 0;
        while (r != 64'h0 && r != '1) begin
            r = {{8{r[63]}}, r[63:8]};
            k++;
        end
        return k;
    endfunction

    function automatic logic [31:0] pattern(input int i);
        case (i % 10)
            0: return 32'h0000_0000;
            1: return 32'h0000_0001;
            2: return 32'hFFFF_FFFF;
            3: return 32'h8000_0000;
            4: return 32'h7FFF_FFFF;
            5: return 32'h1234_5678;
            6: return 32'h0000_00FF;
            7: return 32'h0000_0100;
            8: return 32'hFFFF_FF00;
            default: return 32'h00AB_0000;
        endcase
    endfunction

    function automatic logic [63:0] acc_pat(input int i);
        case (i % 4)
            0: return 64'h0;
            1: return 64'hFFFF_FFFF_FFFF_FFFF;
            2: return 64'hDEAD_BEEF_0000_0001;
            default: return 64'h8000_0000_7FFF_FFFF;
        endcase
    endfunction

    task automatic run_op(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                          input logic [63:0] acc, input bit disturb);
        logic [63:0] exp_r;
        int edges;
        int exp_edges;
        string rtag;
        exp_r     = ref_result(op, a, b, acc);
        exp_edges = ref_digits(op, b) + 2;
        rtag      = disturb ? "R8" : op_tag(op);
        @(negedge clk_i);
        op_i = op; mcand_i = a; mplier_i = b; acc_i = acc; start_i = 1'b1;
        @(negedge clk_i);
        start_i = 1'b0;
        edges = 1;
        check("R7", {63'h0, busy_o}, 64'h1);
        while (!done_o && edges < 12) begin
            if (disturb) begin
                lcg = lcg * 32'd1664525 + 32'd1013904223;
                start_i = 1'b1; op_i = lcg[2:0]; mcand_i = lcg; mplier_i = ~lcg;
                acc_i = {lcg, lcg};
            end
            @(negedge clk_i);
            edges++;
        end
        start_i = 1'b0;
        check("R9", 64'(edges), 64'(exp_edges));
        check(rtag, result_o, exp_r);
        check("R7", {63'h0, busy_o}, 64'h0);
        mcand_i = ~a; mplier_i = ~b; acc_i = ~acc;
        @(negedge clk_i);
        check(disturb ? "R8" : "R7", {62'h0, done_o, busy_o}, 64'h0);
        check("R10", result_o, exp_r);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk_i);
        // R1: values while reset is held
        check("R1", {result_o, 62'h0, busy_o, done_o} == '0 ? 64'h0 : 64'h1, 64'h0);
        rst_ni = 1'b1;
        @(negedge clk_i);
        check("R1", result_o, 64'h0);
        check("R1", {62'h0, busy_o, done_o}, 64'h0);

        // R3: upper accumulator word has no effect on the short accumulate form
        run_op(3'd1, 32'h0000_0003, 32'h0000_0005, 64'hFFFF_FFFF_0000_0007, 1'b0);

        for (int op = 0; op < 8; op++) begin
            for (int i = 0; i < 10; i++) begin
                for (int j = 0; j < 10; j++) begin
                    run_op(3'(op), pattern(i), pattern(j), acc_pat(i + j + op),
                           ((i + j + op) % 7) == 0);
                end
            end
        end

        for (int n = 0; n < 300; n++) begin
            logic [31:0] ra, rb;
            lcg = lcg * 32'd1664525 + 32'd1013904223; ra = lcg;
            lcg = lcg * 32'd1664525 + 32'd1013904223; rb = lcg >> (lcg[4:3] * 8);
            run_op(3'(n % 6), ra, rb, {ra, ~rb}, (n % 5) == 0);
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule